// File: doc/BRIEF.md
# Programmable Multi-CRC Hash Engine

The engine condenses a 32-bit challenge word into an 8-bit authentication code. It holds four independent 8-bit CRC lanes. Lane n takes its configuration from byte n of a 32-bit function key: that byte sets the lane's feedback polynomial and a rotation offset. The offset chooses which challenge bit the lane consumes on each step. Each lane is seeded from byte n of a 32-bit seed key. After a run, the code is the XOR of the four lane registers.

A user first pulses the load strobe to seed the lanes. It then pulses the start strobe with the challenge and function key present on their inputs. The engine latches both, runs 32 steps at one challenge bit per clock (most significant first), and then raises a single-cycle done pulse. If a further run is started without a fresh load, it carries on from whatever CRC state the previous run left behind.

Top module: `mcrc_hash_engine`

## Requirements
- R1: After reset, busy_o and done_o are low and every lane register is zero, so code_o reads 8'h00.
- R2: A load_i pulse while idle sets lane n to seed_key[8n+7:8n]. From the next cycle, code_o shows the XOR of the four seed bytes.
- R3: Lane n uses mask {1, 0, func_key[8n+4:8n], 1}, written as mask bit 7 down to bit 0. For each input bit d, the lane computes fb = crc[7] ^ d and then crc = {crc[6:0],0} ^ (fb ? mask : 0).
- R4: Let r = func_key[8n+7:8n+5]. On step k (k = 0..31), lane n consumes challenge bit (31 - k - r) mod 32.
- R5: A start_i pulse while idle latches the challenge and the function key. busy_o is high from the next cycle for exactly 32 cycles. Changes on those inputs during the run have no effect.
- R6: done_o is high for exactly one cycle, the cycle right after the 32nd step. busy_o is low in that cycle, and code_o then equals the XOR of the four lane registers.
- R7: start_i while busy is ignored. The run keeps its timing and its latched challenge.
- R8: load_i while busy is ignored. The lane registers keep stepping from their current state.
- R9: A run started without a preceding load continues from the lane state left by the previous run.
- R10: While idle and with no load, code_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| func_key | input | 32 | Function key; byte n sets lane n's taps and offset |
| seed_key | input | 32 | Seed key; byte n is lane n's initial value |
| challenge | input | 32 | Challenge word |
| load_i | input | 1 | Seed-load strobe |
| start_i | input | 1 | Run start strobe |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the run is complete |
| code_o | output | 8 | XOR of the four lane registers |

## Verification
A start accepted at one clock edge raises busy_o one cycle later. The 32 steps then take place on the next 32 edges. done_o and the final code_o are therefore due 32 cycles after busy_o first reads high. A load shows up on code_o one cycle after its strobe. The bench drives and samples on falling edges and counts them from the falling edge that follows the strobe. It checks busy_o and done_o on the 31st and on the 32nd of those edges, and checks that done_o has dropped on the 33rd. Expected codes come from a bit-level model of R3 and R4 that the bench keeps for itself.

// File: rtl/mcrc_pkg.sv
package mcrc_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned CRC_W_DEF  = 8;
  localparam int unsigned CHAL_W_DEF = 32;
  localparam int unsigned OFF_W_DEF  = 3;
endpackage

// File: rtl/mcrc_rst_sync.sv
module mcrc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_n_s <= meta_q;
    end
  end
endmodule

// File: rtl/mcrc_seq.sv
module mcrc_seq #(
  parameter int unsigned CHAL_W = 32,
  parameter int unsigned KEY_W  = 32,
  localparam int unsigned IDX_W = $clog2(CHAL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CHAL_W-1:0] challenge,
  input  logic [KEY_W-1:0]  func_key,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  step_idx,
  output logic [CHAL_W-1:0] chal_q,
  output logic [KEY_W-1:0]  func_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHAL_W - 1);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic [CHAL_W-1:0] chal_d;
  logic [KEY_W-1:0]  func_d;
  logic              take_en;

  assign take_en = start_i && !busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    chal_d = chal_q;
    func_d = func_q;
    if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (take_en) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      chal_d = challenge;
      func_d = func_key;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      chal_q <= '0;
      func_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      if (take_en) begin
        chal_q <= chal_d;
        func_q <= func_d;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign step_idx = cnt_q;

  // R5
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && cnt_q == '0));
  // R5
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST) |=> busy_q);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> ($stable(chal_q) && $stable(func_q)));
endmodule

// File: rtl/mcrc_lane.sv
module mcrc_lane #(
  parameter int unsigned CRC_W  = 8,
  parameter int unsigned CHAL_W = 32,
  parameter int unsigned OFF_W  = 3,
  localparam int unsigned IDX_W = $clog2(CHAL_W),
  localparam int unsigned TAP_W = CRC_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [CRC_W-1:0]  seed_byte,
  input  logic [CRC_W-1:0]  func_byte,
  input  logic [CHAL_W-1:0] chal_q,
  input  logic [IDX_W-1:0]  step_idx,
  output logic [CRC_W-1:0]  crc_o
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CHAL_W - 1);

  logic [CRC_W-1:0] crc_q, crc_d, mask;
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] sel;
  logic             din, fb;

  assign off  = func_byte[CRC_W-1 -: OFF_W];
  assign mask = {1'b1, 1'b0, func_byte[TAP_W-1:0], 1'b1};
  assign sel  = TOP_IDX - step_idx - IDX_W'(off);
  assign din  = chal_q[sel];
  assign fb   = crc_q[CRC_W-1] ^ din;

  always_comb begin
    crc_d = crc_q;
    if (load_en) begin
      crc_d = seed_byte;
    end else if (step_en) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? mask : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (load_en || step_en) begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (crc_q == $past(seed_byte)));
  // R10
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(crc_q));
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && step_en));
endmodule

// File: rtl/mcrc_hash_engine.sv
module mcrc_hash_engine
  import mcrc_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned CRC_W  = CRC_W_DEF,
  parameter int unsigned CHAL_W = CHAL_W_DEF,
  parameter int unsigned OFF_W  = OFF_W_DEF,
  localparam int unsigned KEY_W = LANES * CRC_W,
  localparam int unsigned IDX_W = $clog2(CHAL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  func_key,
  input  logic [KEY_W-1:0]  seed_key,
  input  logic [CHAL_W-1:0] challenge,
  input  logic              load_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CRC_W-1:0]  code_o
);
  logic              rst_n_s;
  logic              busy_w, load_en;
  logic [IDX_W-1:0]  step_idx;
  logic [CHAL_W-1:0] chal_q;
  logic [KEY_W-1:0]  func_q;
  logic [CRC_W-1:0]  crc_w [LANES];
  logic [CRC_W-1:0]  code_d;

  mcrc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  mcrc_seq #(.CHAL_W(CHAL_W), .KEY_W(KEY_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_i   (start_i),
    .challenge (challenge),
    .func_key  (func_key),
    .busy_o    (busy_w),
    .done_o    (done_o),
    .step_idx  (step_idx),
    .chal_q    (chal_q),
    .func_q    (func_q)
  );

  assign load_en = load_i && !busy_w;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    mcrc_lane #(.CRC_W(CRC_W), .CHAL_W(CHAL_W), .OFF_W(OFF_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .load_en   (load_en),
      .step_en   (busy_w),
      .seed_byte (seed_key[n*CRC_W +: CRC_W]),
      .func_byte (func_q[n*CRC_W +: CRC_W]),
      .chal_q    (chal_q),
      .step_idx  (step_idx),
      .crc_o     (crc_w[n])
    );
  end

  always_comb begin
    code_d = '0;
    for (int i = 0; i < LANES; i++) begin
      code_d = code_d ^ crc_w[i];
    end
  end

  assign code_o = code_d;
  assign busy_o = busy_w;

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy_o && !load_i && !start_i) |=> $stable(code_o));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n_s |-> (!busy_o && !done_o && code_o == '0));
endmodule

// File: tb/mcrc_hash_engine_test.sv
module mcrc_hash_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] func_key, seed_key, challenge;
  logic        load_i, start_i;
  logic        busy_o, done_o;
  logic [7:0]  code_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] m_crc [4];

  always #5 clk = ~clk;

  mcrc_hash_engine uut (
    .clk(clk), .rst_n(rst_n), .func_key(func_key), .seed_key(seed_key),
    .challenge(challenge), .load_i(load_i), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .code_o(code_o)
  );

  // {func_key, seed_key, challenge}
  localparam logic [95:0] VEC [0:5] = '{
    {32'h1F2E_3D4C, 32'hA5C3_0F96, 32'hDEAD_BEEF},
    {32'hE07F_8113, 32'h0102_0408, 32'h8000_0001},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678},
    {32'hFFFF_FFFF, 32'h5A5A_A5A5, 32'hFFFF_FFFF},
    {32'h6B29_D4E7, 32'h3C00_81FE, 32'h0F0F_F0F0},
    {32'hA1B2_C3D4, 32'h7700_0099, 32'h0000_0000}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_step(logic [7:0] c, logic [7:0] f, logic d);
    logic [7:0] mask;
    logic       fb;
    mask = {1'b1, 1'b0, f[4:0], 1'b1};
    fb   = c[7] ^ d;
    return {c[6:0], 1'b0} ^ (fb ? mask : 8'h00);
  endfunction

  function automatic logic [7:0] m_code();
    return m_crc[0] ^ m_crc[1] ^ m_crc[2] ^ m_crc[3];
  endfunction

  task automatic m_load(logic [31:0] s);
    for (int n = 0; n < 4; n++) m_crc[n] = s[n*8 +: 8];
  endtask

  task automatic m_run(logic [31:0] f, logic [31:0] c);
    for (int k = 0; k < 32; k++) begin
      for (int n = 0; n < 4; n++) begin
        int r, idx;
        r   = int'(f[n*8+5 +: 3]);
        idx = (31 - k - r + 64) % 32;
        m_crc[n] = m_step(m_crc[n], f[n*8 +: 8], c[idx]);
      end
    end
  endtask

  task automatic do_load(logic [31:0] s);
    seed_key = s;
    load_i   = 1'b1;
    @(negedge clk);
    load_i   = 1'b0;
    m_load(s);
  endtask

  // Leaves the bench at the falling edge that follows the accepting edge
  task automatic do_start(logic [31:0] f, logic [31:0] c);
    func_key  = f;
    challenge = c;
    start_i   = 1'b1;
    @(negedge clk);
    start_i   = 1'b0;
  endtask

  // From the falling edge after the start edge: run ends 32 edges later
  task automatic finish_run(int spent, string tag);
    repeat (31 - spent) @(negedge clk);
    chk({tag, " R5 busy at step 32"}, busy_o, 1'b1);
    chk({tag, " R6 no early done"}, done_o, 1'b0);
    @(negedge clk);
    chk({tag, " R6 done"}, done_o, 1'b1);
    chk({tag, " R6 busy low"}, busy_o, 1'b0);
    chk({tag, " R3 R4 code"}, code_o, m_code());
    @(negedge clk);
    chk({tag, " R6 done one cycle"}, done_o, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; start_i = 1'b0;
    func_key = '0; seed_key = '0; challenge = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o, 1'b0);
    chk("R1 done", done_o, 1'b0);
    chk("R1 code", code_o, 8'h00);

    for (int v = 0; v < 6; v++) begin
      logic [31:0] f, s, c;
      {f, s, c} = VEC[v];
      do_load(s);
      chk("R2 seed xor", code_o, s[31:24] ^ s[23:16] ^ s[15:8] ^ s[7:0]);
      do_start(f, c);
      chk("R5 busy rises", busy_o, 1'b1);
      m_run(f, c);
      finish_run(0, "vec");
      repeat (3) @(negedge clk);
      chk("R10 code holds", code_o, m_code());
    end

    // Identical lanes cancel: same function bytes and seed bytes give 0
    do_load(32'h3C3C_3C3C);
    do_start(32'h5D5D_5D5D, 32'hC001_D00D);
    m_run(32'h5D5D_5D5D, 32'hC001_D00D);
    finish_run(0, "same lanes");
    chk("R6 xor of equal lanes", code_o, 8'h00);

    // All-zero case stays zero
    do_load(32'h0);
    do_start(32'h0, 32'h0);
    m_run(32'h0, 32'h0);
    finish_run(0, "zero");
    chk("R3 zero in zero out", code_o, 8'h00);

    // R9: second run without reload continues
    do_load(32'h1357_9BDF);
    do_start(32'h2468_ACE0, 32'hFEDC_BA98);
    m_run(32'h2468_ACE0, 32'hFEDC_BA98);
    finish_run(0, "R9 first");
    do_start(32'h9ABC_DEF0, 32'h0F1E_2D3C);
    m_run(32'h9ABC_DEF0, 32'h0F1E_2D3C);
    finish_run(0, "R9 chained");

    // R7 and R5: start and input changes while busy ignored
    do_load(32'h8421_1248);
    do_start(32'h7E3A_51C9, 32'hA0B1_C2D3);
    m_run(32'h7E3A_51C9, 32'hA0B1_C2D3);
    repeat (3) @(negedge clk);
    func_key  = 32'hFFFF_0000;
    challenge = 32'h5555_AAAA;
    start_i   = 1'b1;
    @(negedge clk);
    start_i   = 1'b0;
    finish_run(4, "R7 ignored start");

    // R8: load while busy ignored
    do_load(32'h0BAD_F00D);
    do_start(32'h4C7B_19E2, 32'h3141_5926);
    m_run(32'h4C7B_19E2, 32'h3141_5926);
    repeat (5) @(negedge clk);
    seed_key = 32'hFFFF_FFFF;
    load_i   = 1'b1;
    @(negedge clk);
    load_i   = 1'b0;
    finish_run(6, "R8 ignored load");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule